// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog for a system controller. A free-running up-counter advances once per clock while the timer is on. When it reaches the limit picked by a one-hot exponent field, it wraps to zero, raises an interrupt flag and, if allowed, sends a one-cycle system reset request. Software keeps the system alive by writing a two-word service key, which restarts the count.

All access goes through a small register port with three addresses: 0 is the control word, which also takes the keys, 1 is the low half of the count and 2 is the high half. The control word is guarded. Only the single write that follows the unlock key pair is taken, and only if it holds a legal selection. Read data is combinational from the address. A read strobe on the low half also latches the high half, so the two reads form one consistent value.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the control word reads 0x0001 (timer off, reset request off, flag clear, shortest timeout selected), both count halves read 0, and irq and sys_rst_req are low.
- R2: Control word layout: bit 15 turns the timer on, bit 14 allows the reset request, bit 12 is the interrupt flag, and bits [SEL_W-1:0] hold the one-hot timeout selection. Selection bit 0 means 2^SHORT_EXP cycles, and bit i (i >= 1) means 2^(LONG_EXP_BASE+i-1) cycles. The other bits read as 0. Addresses: 0 control, 1 count low half, 2 count high half.
- R3: A write to address 0 changes the control word only when it directly follows the writes 0x3333 and then 0xCCCC to address 0. Any other write to address 0 leaves the control word unchanged.
- R4: In the middle of a key pair, any address-0 write other than the expected second word returns the sequence to idle, and that includes a repeat of the first word. After one control write has been taken, the register is locked again.
- R5: Writing 0xAAAA and then 0x5555 to address 0 sets the count to zero. A pair broken by another address-0 write between the two words has no effect on the count.
- R6: While the timer is on, the count rises by one per clock. Exactly 2^N clocks after a restart (N from the selection), irq goes high and the count reads 0.
- R7: A control write that is taken clears the interrupt flag when bit 12 is 1 and leaves the flag as it was when bit 12 is 0. An expiry sets the flag.
- R8: sys_rst_req is high for exactly one clock at an expiry, and only when both the timer and the reset request are on.
- R9: While the timer is off, the count stays at zero and never expires.
- R10: A control write is rejected as a whole, and the previous contents are kept, when its selection field does not have exactly one bit set or when any bit outside fields 15, 14, 12 and the selection is 1.
- R11: A read strobe on address 1 copies the high half of the count at that moment into a holding register, and reads of address 2 return that held value.
- R12: Writes to addresses 1 and 2 change neither the count nor the progress of a key sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (used for the high-half capture) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| irq | output | 1 | Interrupt flag |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bound checker watches, on every cycle, the rules that hold over a short window:

- the reset request is a lone pulse and is gated by the two enables,
- the count is zero after a cycle with the timer off,
- an expiry always sets the flag and wraps the count,
- the selection stays one-hot,
- the control fields change only after the unlock pair.

Only the bench's scenarios can show the full 2^N timeout lengths, the accept and reject decisions for key orderings and illegal selections, whether a broken service pair restarts the count, and whether the held high half agrees with a low-half read taken just before a carry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int REG_W = 16;

   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_CLO  = 2'd1;
   localparam logic [1:0] ADR_CHI  = 2'd2;

   localparam int BIT_EN  = 15;
   localparam int BIT_RST = 14;
   localparam int BIT_IRQ = 12;

   localparam logic [REG_W-1:0] KEY_OPEN_A = 16'h3333;
   localparam logic [REG_W-1:0] KEY_OPEN_B = 16'hCCCC;
   localparam logic [REG_W-1:0] KEY_KICK_A = 16'hAAAA;
   localparam logic [REG_W-1:0] KEY_KICK_B = 16'h5555;

   typedef enum logic [1:0] {
      KS_IDLE,
      KS_HALF,
      KS_OPEN,
      KS_KICK
   } key_st_e;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
   import wdt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [REG_W-1:0] wdata,
   output key_st_e          state,
   output logic             load_ctl,
   output logic             kick
);
   key_st_e nxt;

   always_comb begin
      nxt = state;
      if (ctl_wr) begin
         unique case (state)
            KS_IDLE: begin
               if (wdata == KEY_OPEN_A)      nxt = KS_HALF;
               else if (wdata == KEY_KICK_A) nxt = KS_KICK;
               else                          nxt = KS_IDLE;
            end
            KS_HALF: nxt = (wdata == KEY_OPEN_B) ? KS_OPEN : KS_IDLE;
            KS_OPEN: nxt = KS_IDLE;
            KS_KICK: nxt = KS_IDLE;
            default: nxt = KS_IDLE;
         endcase
      end
   end

   assign load_ctl = ctl_wr && (state == KS_OPEN);
   assign kick     = ctl_wr && (state == KS_KICK) && (wdata == KEY_KICK_B);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= KS_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int SEL_W         = 8,
   parameter int SHORT_EXP     = 14,
   parameter int LONG_EXP_BASE = 24,
   parameter int CNT_W         = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [SEL_W-1:0] hit;

   for (genvar i = 0; i < SEL_W; i++) begin : g_lim
      if (i == 0) begin : g_short
         localparam logic [CNT_W-1:0] LIM = (ONE << SHORT_EXP) - ONE;
         assign hit[i] = sel[i] && (count >= LIM);
      end else begin : g_long
         localparam logic [CNT_W-1:0] LIM = (ONE << (LONG_EXP_BASE + i - 1)) - ONE;
         assign hit[i] = sel[i] && (count >= LIM);
      end
   end

   assign expire = en && (|hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count <= '0;
      else if (!en)              count <= '0;
      else if (restart || expire) count <= '0;
      else                       count <= count + ONE;
   end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
   import wdt_pkg::*;
#(
   parameter int SEL_W         = 8,
   parameter int SHORT_EXP     = 14,
   parameter int LONG_EXP_BASE = 24,
   parameter int CNT_W         = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [1:0]  reg_addr,
   input  logic [15:0] reg_wdata,
   output logic [15:0] reg_rdata,
   output logic        irq,
   output logic        sys_rst_req
);
   localparam int HI_W = CNT_W - REG_W;
   localparam logic [REG_W-1:0] SEL_MASK  = (16'h1 << SEL_W) - 16'h1;
   localparam logic [REG_W-1:0] KEEP_MASK = (16'h1 << BIT_EN) | (16'h1 << BIT_RST)
                                          | (16'h1 << BIT_IRQ) | SEL_MASK;
   localparam logic [SEL_W-1:0] SEL_RST   = {{(SEL_W-1){1'b0}}, 1'b1};

   if (SEL_W < 2 || SEL_W > BIT_IRQ) begin : g_bad_sel
      $error("SEL_W must lie in 2..12");
   end
   if (SHORT_EXP < 1 || SHORT_EXP >= LONG_EXP_BASE) begin : g_bad_exp
      $error("SHORT_EXP must be positive and below LONG_EXP_BASE");
   end
   if (CNT_W <= REG_W || CNT_W > 2 * REG_W) begin : g_bad_cnt
      $error("CNT_W must lie in 17..32");
   end
   if (LONG_EXP_BASE + SEL_W - 2 >= CNT_W) begin : g_bad_fit
      $error("largest timeout does not fit in CNT_W");
   end

   key_st_e          key_st;
   logic             load_ctl;
   logic             kick;
   logic             ctl_en;
   logic             ctl_rst;
   logic [SEL_W-1:0] ctl_sel;
   logic             irq_q;
   logic             rst_q;
   logic [CNT_W-1:0] cnt;
   logic             expire;
   logic [HI_W-1:0]  hi_hold;
   logic             ctl_wr;
   logic             take;

   assign ctl_wr = reg_wr && (reg_addr == ADR_CTRL);
   assign take   = load_ctl
                && ($countones(reg_wdata[SEL_W-1:0]) == 1)
                && ((reg_wdata & ~KEEP_MASK) == '0);

   wdt_key_seq u_keys (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (ctl_wr),
      .wdata    (reg_wdata),
      .state    (key_st),
      .load_ctl (load_ctl),
      .kick     (kick)
   );

   wdt_counter #(
      .SEL_W         (SEL_W),
      .SHORT_EXP     (SHORT_EXP),
      .LONG_EXP_BASE (LONG_EXP_BASE),
      .CNT_W         (CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (ctl_en),
      .restart (kick),
      .sel     (ctl_sel),
      .count   (cnt),
      .expire  (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en  <= 1'b0;
         ctl_rst <= 1'b0;
         ctl_sel <= SEL_RST;
      end else if (take) begin
         ctl_en  <= reg_wdata[BIT_EN];
         ctl_rst <= reg_wdata[BIT_RST];
         ctl_sel <= reg_wdata[SEL_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         irq_q <= 1'b0;
      else if (expire)                    irq_q <= 1'b1;
      else if (take && reg_wdata[BIT_IRQ]) irq_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_q <= 1'b0;
      else        rst_q <= expire && ctl_rst;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                hi_hold <= '0;
      else if (reg_rd && (reg_addr == ADR_CLO)) hi_hold <= cnt[CNT_W-1:REG_W];
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         ADR_CTRL: begin
            reg_rdata[BIT_EN]      = ctl_en;
            reg_rdata[BIT_RST]     = ctl_rst;
            reg_rdata[BIT_IRQ]     = irq_q;
            reg_rdata[SEL_W-1:0]   = ctl_sel;
         end
         ADR_CLO: reg_rdata = cnt[REG_W-1:0];
         ADR_CHI: reg_rdata[HI_W-1:0] = hi_hold;
         default: reg_rdata = '0;
      endcase
   end

   assign irq         = irq_q;
   assign sys_rst_req = rst_q;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
   import wdt_pkg::*;
#(
   parameter int SEL_W = 8,
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             rst_en,
   input logic [SEL_W-1:0] sel,
   input logic             irq,
   input logic             sys_rst_req,
   input logic [CNT_W-1:0] count,
   input logic             expire,
   input key_st_e          key_st
);
   // R8
   rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |=> !sys_rst_req);

   // R8
   rst_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |-> $past(en && rst_en));

   // R9
   off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (count == '0));

   // R6
   expire_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (irq && (count == '0)));

   // R10
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sel) == 1);

   // R3
   ctrl_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({en, rst_en, sel}) |-> ($past(key_st) == KS_OPEN));
endmodule

bind keyed_wdt wdt_chk #(
   .SEL_W (SEL_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en          (ctl_en),
   .rst_en      (ctl_rst),
   .sel         (ctl_sel),
   .irq         (irq),
   .sys_rst_req (sys_rst_req),
   .count       (cnt),
   .expire      (expire),
   .key_st      (key_st)
);

// File: tb/sim_keyed_wdt.sv
module sim_keyed_wdt;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] reg_rdata;
   logic        irq;
   logic        sys_rst_req;

   int n_chk = 0;
   int n_fail = 0;
   int pulses = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   keyed_wdt #(
      .SEL_W         (8),
      .SHORT_EXP     (4),
      .LONG_EXP_BASE (13),
      .CNT_W         (32)
   ) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr      (reg_wr),
      .reg_rd      (reg_rd),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .irq         (irq),
      .sys_rst_req (sys_rst_req)
   );

   always @(negedge clk) if (rst_n && sys_rst_req) pulses++;

   // {addr, wdata, expected control word after the write}
   localparam int NV = 33;
   localparam logic [33:0] TBL [NV] = '{
      {2'd0, 16'h1234, 16'h0001},
      {2'd0, 16'h3333, 16'h0001},
      {2'd0, 16'hCCCC, 16'h0001},
      {2'd0, 16'h4002, 16'h4002},
      {2'd0, 16'h8004, 16'h4002},
      {2'd0, 16'h3333, 16'h4002},
      {2'd0, 16'h1111, 16'h4002},
      {2'd0, 16'hCCCC, 16'h4002},
      {2'd0, 16'h8004, 16'h4002},
      {2'd0, 16'h3333, 16'h4002},
      {2'd0, 16'h3333, 16'h4002},
      {2'd0, 16'hCCCC, 16'h4002},
      {2'd0, 16'h8004, 16'h4002},
      {2'd0, 16'hAAAA, 16'h4002},
      {2'd0, 16'hCCCC, 16'h4002},
      {2'd0, 16'h8004, 16'h4002},
      {2'd0, 16'h3333, 16'h4002},
      {2'd1, 16'hFFFF, 16'h4002},
      {2'd0, 16'hCCCC, 16'h4002},
      {2'd0, 16'h0003, 16'h4002},
      {2'd0, 16'h3333, 16'h4002},
      {2'd0, 16'hCCCC, 16'h4002},
      {2'd0, 16'h0000, 16'h4002},
      {2'd0, 16'h3333, 16'h4002},
      {2'd0, 16'hCCCC, 16'h4002},
      {2'd0, 16'h2001, 16'h4002},
      {2'd0, 16'h3333, 16'h4002},
      {2'd2, 16'h0000, 16'h4002},
      {2'd0, 16'hCCCC, 16'h4002},
      {2'd0, 16'h0080, 16'h0080},
      {2'd0, 16'h3333, 16'h0080},
      {2'd0, 16'hCCCC, 16'h0080},
      {2'd0, 16'h0001, 16'h0001}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [15:0] v);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      reg_rd = 1'b1; reg_addr = a;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic setctl(input logic [15:0] d);
      wr(2'd0, 16'h3333);
      wr(2'd0, 16'hCCCC);
      wr(2'd0, d);
   endtask

   task automatic kick();
      wr(2'd0, 16'hAAAA);
      wr(2'd0, 16'h5555);
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (199000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      peek(2'd0, v); chk("R1 control", v, 16'h0001);
      peek(2'd1, v); chk("R1 count low", v, 16'h0);
      peek(2'd2, v); chk("R1 count high", v, 16'h0);
      chk("R1 irq", irq, 1'b0);
      chk("R1 sys_rst_req", sys_rst_req, 1'b0);

      // R3 R4 R10 R12: key sequence table
      for (int i = 0; i < NV; i++) begin
         wr(TBL[i][33:32], TBL[i][31:16]);
         peek(2'd0, v);
         chk($sformatf("R3 R4 R10 R12 table step %0d", i), v, TBL[i][15:0]);
      end

      // R9 timer off: count stays zero
      wait_n(40);
      peek(2'd1, v); chk("R9 count while off", v, 16'h0);
      chk("R9 no irq while off", irq, 1'b0);

      // R6 R2 short selection: 2^4 cycles
      setctl(16'h8001);
      kick();
      wait_n(15);
      peek(2'd1, v); chk("R6 count before short expiry", v, 16'd15);
      chk("R6 irq before short expiry", irq, 1'b0);
      wait_n(1);
      chk("R6 R2 irq at 2^SHORT", irq, 1'b1);
      peek(2'd1, v); chk("R6 count wraps", v, 16'h0);

      // R7 flag write-one-to-clear
      setctl(16'h8002);
      peek(2'd0, v); chk("R7 flag kept on bit12=0", v, 16'h9002);
      setctl(16'h9002);
      peek(2'd0, v); chk("R7 flag cleared on bit12=1", v, 16'h8002);
      chk("R7 irq low after clear", irq, 1'b0);

      // R6 R2 long selection bit 1: 2^13 cycles
      kick();
      wait_n(8191);
      chk("R6 irq before long expiry", irq, 1'b0);
      peek(2'd1, v); chk("R6 count before long expiry", v, 16'd8191);
      wait_n(1);
      chk("R6 R2 irq at long selection", irq, 1'b1);
      chk("R8 no pulse without reset enable", pulses, 0);

      // R5 broken and complete service pair
      kick();
      wait_n(10);
      wr(2'd0, 16'hAAAA);
      wr(2'd0, 16'h1234);
      wr(2'd0, 16'h5555);
      peek(2'd1, v); chk("R5 broken pair ignored", v, 16'd13);
      kick();
      peek(2'd1, v); chk("R5 service restart", v, 16'h0);

      // R8 reset pulse
      setctl(16'hD001);
      base = pulses;
      kick();
      wait_n(15);
      chk("R8 no pulse early", sys_rst_req, 1'b0);
      wait_n(1);
      chk("R8 pulse at expiry", sys_rst_req, 1'b1);
      wait_n(1);
      chk("R8 pulse one cycle", sys_rst_req, 1'b0);
      chk("R8 pulse count", pulses, base + 1);

      // R9 R8 timer off with reset enable set
      setctl(16'h5001);
      base = pulses;
      wait_n(40);
      peek(2'd1, v); chk("R9 count held after disable", v, 16'h0);
      chk("R8 no pulse while off", pulses, base);

      // R11 snapshot across a carry into the high half
      setctl(16'h8020);
      kick();
      wait_n(65535);
      rd(2'd1, v); chk("R11 low read", v, 16'hFFFF);
      wait_n(4);
      peek(2'd2, v); chk("R11 held high half", v, 16'h0000);
      rd(2'd1, v); chk("R11 second low read", v, 16'h0004);
      peek(2'd2, v); chk("R11 new held high half", v, 16'h0001);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule